// File: doc/BRIEF.md
# SPI Transfer Task and Event Controller

This block is the register-level sequencer that sits between a simple register port and a serial-peripheral transfer engine. Software triggers actions by writing 1 to task addresses: start, stop, suspend and resume. The block tells the engine what to do through one-cycle start and stop pulses and a hold level. The engine reports back through a busy level and two pulses, one for receive count reached and one for transmit count reached. The block records five event flags from these: transfer started, transfer stopped, receive done, transmit done and both done (END). Software can clear each flag. A mask of interrupt enables, written through separate set and clear addresses, gates the flags onto a single interrupt line. An optional shortcut starts the next transfer as soon as END occurs.

The sequencer has four states: Idle, Run, Hold and Halt. Idle goes to Run on a start task, and to Halt on a stop task. Run goes to Halt on stop. On END it stays in Run if the shortcut is set (relaunch) and otherwise returns to Idle; a suspend task moves it to Hold. Hold goes back to Run on resume, to Halt on stop, and on END it behaves as Run does. Halt returns to Idle on the first cycle in which the engine reports not busy. A transfer counts as active in Run and in Hold.

Top module: `spi_task_ctrl`

## Requirements
- R1: After reset all event flags, the enable mask and the shortcut read 0. irq, eng_start, eng_stop and eng_hold are low, and the sequencer is Idle.
- R2: A write of data bit 0 = 1 to address 0 (start) in Idle makes eng_start high for exactly the following cycle and sets the started flag (read at address 4, bit 0) on the same edge. A write with bit 0 = 0 does nothing. Task addresses 0 to 3 read as 0.
- R3: A start task while a transfer is active or stopping (Run, Hold, Halt) is ignored: eng_start stays low and the started flag is not set.
- R4: The receive-done flag (address 6) and the transmit-done flag (address 7) are set on the edge that samples eng_rx_done or eng_tx_done high.
- R5: The END flag (address 8) is set on the edge where both the receive and the transmit count have been reached in the current active transfer, in either order or in the same cycle. Without the shortcut the sequencer then returns to Idle.
- R6: A write of bit 0 = 0 to an event address (4 to 8) clears that flag. A write of bit 0 = 1 there has no effect. A hardware set in the same cycle wins over a clear.
- R7: Writing a mask to address 9 sets those enable bits, and writing a mask to address 10 clears them. Both addresses read back the current mask. Bit k enables event k: started 0, stopped 1, receive done 2, transmit done 3, END 4.
- R8: irq is the OR over the five events of flag AND enable. It follows a flag or enable change on the same edge.
- R9: A suspend task (address 2) in Run raises eng_hold on that edge. A resume task (address 3) in Hold lowers it. Suspend outside Run and resume outside Hold are ignored.
- R10: A stop task (address 1) outside Halt makes eng_stop high for the following cycle and drops eng_hold. The stopped flag (address 5) is set on the first edge in Halt with eng_busy low, and not before.
- R11: With the shortcut bit (address 11, bit 0) set, END makes eng_start pulse in the following cycle and sets the started flag, and the transfer stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NEV (5) | Write data |
| reg_rdata | output | NEV (5) | Read data for reg_addr, combinational |
| eng_start | output | 1 | One-cycle launch request to the engine |
| eng_stop | output | 1 | One-cycle abort request to the engine |
| eng_hold | output | 1 | Engine must pause at the next byte boundary with SCK idle |
| eng_busy | input | 1 | Engine is still shifting |
| eng_rx_done | input | 1 | Pulse: receive count reached |
| eng_tx_done | input | 1 | Pulse: transmit count reached |
| irq | output | 1 | Interrupt request |

## Verification
Flags, the enable mask, the shortcut bit, eng_hold and irq all change on the edge that samples the write or the engine pulse. eng_start and eng_stop are registered, so each is high during the cycle after that edge. The stopped flag appears one edge after eng_busy falls in Halt. The bench drives inputs and samples outputs on falling edges. Each check is placed at the first falling edge after the edge on which its result is due, and pulse widths are checked one cycle later. A random phase mixes mask writes, flag clears, engine pulses and stops against a bench model of the flags and the mask.

// File: rtl/stc_pkg.sv
package stc_pkg;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD, S_HALT} seq_state_t;

    localparam int NEV        = 5;
    localparam int EV_STARTED = 0;
    localparam int EV_STOPPED = 1;
    localparam int EV_RXDONE  = 2;
    localparam int EV_TXDONE  = 3;
    localparam int EV_END     = 4;

    localparam int A_START    = 0;
    localparam int A_STOP     = 1;
    localparam int A_SUSP     = 2;
    localparam int A_RES      = 3;
    localparam int A_EV0      = 4;
    localparam int A_IEN_SET  = A_EV0 + NEV;
    localparam int A_IEN_CLR  = A_IEN_SET + 1;
    localparam int A_SHORT    = A_IEN_CLR + 1;
endpackage

// File: rtl/stc_decode.sv
module stc_decode
    import stc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wbit0,
    input  logic [NEV-1:0]    ev_flags,
    input  logic [NEV-1:0]    ien,
    input  logic              shortcut,
    output logic              t_start,
    output logic              t_stop,
    output logic              t_susp,
    output logic              t_res,
    output logic [NEV-1:0]    ev_clr,
    output logic              ien_set_we,
    output logic              ien_clr_we,
    output logic              sc_we,
    output logic [NEV-1:0]    reg_rdata
);
    // tasks trigger only on a written 1 in bit 0 (R2)
    assign t_start    = reg_we && wbit0 && (reg_addr == ADDR_W'(A_START));
    assign t_stop     = reg_we && wbit0 && (reg_addr == ADDR_W'(A_STOP));
    assign t_susp     = reg_we && wbit0 && (reg_addr == ADDR_W'(A_SUSP));
    assign t_res      = reg_we && wbit0 && (reg_addr == ADDR_W'(A_RES));
    assign ien_set_we = reg_we && (reg_addr == ADDR_W'(A_IEN_SET));
    assign ien_clr_we = reg_we && (reg_addr == ADDR_W'(A_IEN_CLR));
    assign sc_we      = reg_we && (reg_addr == ADDR_W'(A_SHORT));

    // event clear on a written 0 (R6)
    for (genvar i = 0; i < NEV; i++) begin : g_clr
        assign ev_clr[i] = reg_we && !wbit0 && (reg_addr == ADDR_W'(A_EV0 + i));
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NEV; i++) begin
            if (reg_addr == ADDR_W'(A_EV0 + i)) reg_rdata[0] = ev_flags[i];
        end
        if (reg_addr == ADDR_W'(A_IEN_SET) || reg_addr == ADDR_W'(A_IEN_CLR))
            reg_rdata = ien;
        if (reg_addr == ADDR_W'(A_SHORT)) reg_rdata[0] = shortcut;
    end
endmodule

// File: rtl/stc_events.sv
module stc_events
    import stc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_set,
    input  logic [NEV-1:0] ev_clr,
    input  logic           ien_set_we,
    input  logic           ien_clr_we,
    input  logic           sc_we,
    input  logic [NEV-1:0] wdata,
    output logic [NEV-1:0] ev_flags,
    output logic [NEV-1:0] ien,
    output logic           shortcut,
    output logic           irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_flags <= '0;
            ien      <= '0;
            shortcut <= 1'b0;
        end else begin
            // hardware set wins over a software clear (R6)
            ev_flags <= (ev_flags & ~ev_clr) | ev_set;
            ien      <= (ien | (ien_set_we ? wdata : '0)) & ~(ien_clr_we ? wdata : '0);
            if (sc_we) shortcut <= wdata[0];
        end
    end

    assign irq = |(ev_flags & ien);

    for (genvar k = 0; k < NEV; k++) begin : g_chk
        // R4/R5: a flag only rises after its set request
        assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ev_flags[k]) |-> $past(ev_set[k]));
    end

    // R7: clear address removes enable bit 0 on the next edge
    assert_ien_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_clr_we && wdata[0]) |=> !ien[0]);
endmodule

// File: rtl/stc_seq.sv
module stc_seq
    import stc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           t_start,
    input  logic           t_stop,
    input  logic           t_susp,
    input  logic           t_res,
    input  logic           shortcut,
    input  logic           eng_busy,
    input  logic           eng_rx_done,
    input  logic           eng_tx_done,
    output logic           eng_start,
    output logic           eng_stop,
    output logic           eng_hold,
    output logic [NEV-1:0] ev_set
);
    seq_state_t state_q, state_d;
    logic rx_seen_q, tx_seen_q, rx_seen_d, tx_seen_d;
    logic active, end_hit, launch, halt_done;

    always_comb begin
        active    = (state_q == S_RUN) || (state_q == S_HOLD);
        end_hit   = active && (rx_seen_q || eng_rx_done) && (tx_seen_q || eng_tx_done);
        halt_done = (state_q == S_HALT) && !eng_busy;
        launch    = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (t_start) begin
                    state_d = S_RUN;
                    launch  = 1'b1;
                end else if (t_stop) begin
                    state_d = S_HALT;
                end
            end
            S_RUN: begin
                if (t_stop) state_d = S_HALT;
                else if (end_hit) begin
                    if (shortcut) launch = 1'b1;
                    else state_d = S_IDLE;
                end else if (t_susp) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (t_stop) state_d = S_HALT;
                else if (end_hit) begin
                    if (shortcut) begin
                        launch  = 1'b1;
                        state_d = S_RUN;
                    end else state_d = S_IDLE;
                end else if (t_res) state_d = S_RUN;
            end
            S_HALT: begin
                if (!eng_busy) state_d = S_IDLE;
            end
        endcase
        rx_seen_d = (launch || end_hit) ? 1'b0 : (rx_seen_q || (active && eng_rx_done));
        tx_seen_d = (launch || end_hit) ? 1'b0 : (tx_seen_q || (active && eng_tx_done));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            rx_seen_q <= 1'b0;
            tx_seen_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rx_seen_q <= rx_seen_d;
            tx_seen_q <= tx_seen_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_stop  <= 1'b0;
        end else begin
            eng_start <= launch;
            eng_stop  <= (state_d == S_HALT) && (state_q != S_HALT);
        end
    end

    always_comb begin
        eng_hold            = (state_q == S_HOLD);
        ev_set              = '0;
        ev_set[EV_STARTED]  = launch;
        ev_set[EV_STOPPED]  = halt_done;
        ev_set[EV_RXDONE]   = eng_rx_done;
        ev_set[EV_TXDONE]   = eng_tx_done;
        ev_set[EV_END]      = end_hit;
    end

    // R10: a stop request never coincides with a launch request
    assert_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop |-> !eng_start);
    // R3: no launch is issued while the engine is held
    assert_hold_nolaunch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_hold |-> !eng_start);
    // R9: hold only rises after a suspend task
    assert_hold_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_hold) |-> $past(t_susp));
endmodule

// File: rtl/spi_task_ctrl.sv
module spi_task_ctrl
    import stc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NEV-1:0]    reg_wdata,
    output logic [NEV-1:0]    reg_rdata,
    output logic              eng_start,
    output logic              eng_stop,
    output logic              eng_hold,
    input  logic              eng_busy,
    input  logic              eng_rx_done,
    input  logic              eng_tx_done,
    output logic              irq
);
    logic t_start, t_stop, t_susp, t_res;
    logic ien_set_we, ien_clr_we, sc_we, shortcut;
    logic [NEV-1:0] ev_clr, ev_set, ev_flags, ien;

    stc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_we(reg_we), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
        .ev_flags(ev_flags), .ien(ien), .shortcut(shortcut),
        .t_start(t_start), .t_stop(t_stop), .t_susp(t_susp), .t_res(t_res),
        .ev_clr(ev_clr), .ien_set_we(ien_set_we), .ien_clr_we(ien_clr_we),
        .sc_we(sc_we), .reg_rdata(reg_rdata)
    );

    stc_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .t_start(t_start), .t_stop(t_stop), .t_susp(t_susp), .t_res(t_res),
        .shortcut(shortcut), .eng_busy(eng_busy),
        .eng_rx_done(eng_rx_done), .eng_tx_done(eng_tx_done),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_hold(eng_hold),
        .ev_set(ev_set)
    );

    stc_events u_ev (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
        .ien_set_we(ien_set_we), .ien_clr_we(ien_clr_we), .sc_we(sc_we),
        .wdata(reg_wdata), .ev_flags(ev_flags), .ien(ien),
        .shortcut(shortcut), .irq(irq)
    );
endmodule

// File: tb/sim_spi_task_ctrl.sv
module sim_spi_task_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic       eng_start, eng_stop, eng_hold, irq;
    logic       eng_busy = 1'b0, eng_rx_done = 1'b0, eng_tx_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int v;

    localparam int AST = 0, ASP = 1, ASU = 2, ARS = 3, AEV = 4;
    localparam int ASET = 9, ACLR = 10, ASC = 11;

    always #10 clk = ~clk;

    spi_task_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_stop(eng_stop), .eng_hold(eng_hold), .eng_busy(eng_busy),
        .eng_rx_done(eng_rx_done), .eng_tx_done(eng_tx_done), .irq(irq)
    );

    function automatic int exp_irq(logic [4:0] e, logic [4:0] m);
        return int'(|(e & m));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_pulse(int a, int d, logic rx, logic tx);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 5'(d);
        eng_rx_done = rx; eng_tx_done = tx;
        @(negedge clk);
        reg_we = 1'b0; eng_rx_done = 1'b0; eng_tx_done = 1'b0;
    endtask

    task automatic wr(int a, int d);
        wr_pulse(a, d, 1'b0, 1'b0);
    endtask

    task automatic pulse(logic rx, logic tx);
        @(negedge clk);
        eng_rx_done = rx; eng_tx_done = tx;
        @(negedge clk);
        eng_rx_done = 1'b0; eng_tx_done = 1'b0;
    endtask

    task automatic rd(int a, output int val);
        reg_addr = 4'(a);
        #1 val = int'(reg_rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_we = 1'b0; eng_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [4:0] mev, mien;
        void'($urandom(32'h1234_5a5a));
        do_reset();
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 eng_start", int'(eng_start), 0);
        chk("R1 eng_stop", int'(eng_stop), 0);
        chk("R1 eng_hold", int'(eng_hold), 0);
        rd(AEV, v);  chk("R1 started flag", v, 0);
        rd(ASET, v); chk("R1 mask", v, 0);
        rd(ASC, v);  chk("R1 shortcut", v, 0);

        // R2 start
        wr(AST, 0);
        chk("R2 zero write no start", int'(eng_start), 0);
        rd(AEV, v); chk("R2 zero write no flag", v, 0);
        wr(AST, 1);
        chk("R2 eng_start pulse", int'(eng_start), 1);
        rd(AEV, v); chk("R2 started flag", v, 1);
        @(negedge clk);
        chk("R2 pulse one cycle", int'(eng_start), 0);
        rd(AST, v); chk("R2 task reads zero", v, 0);
        wr(AEV, 0);
        rd(AEV, v); chk("R6 clear started", v, 0);

        // R3 start while running
        wr(AST, 1);
        chk("R3 no start when running", int'(eng_start), 0);
        rd(AEV, v); chk("R3 started not set", v, 0);

        // R4 R5 done pulses and END
        pulse(1'b1, 1'b0);
        rd(AEV + 2, v); chk("R4 rx flag", v, 1);
        rd(AEV + 4, v); chk("R5 no end on rx only", v, 0);
        pulse(1'b0, 1'b1);
        rd(AEV + 3, v); chk("R4 tx flag", v, 1);
        rd(AEV + 4, v); chk("R5 end flag", v, 1);
        wr(AEV + 4, 1);
        rd(AEV + 4, v); chk("R6 write one keeps flag", v, 1);
        wr(AEV + 4, 0);
        rd(AEV + 4, v); chk("R6 write zero clears", v, 0);
        wr(AST, 1);
        chk("R5 idle after end", int'(eng_start), 1);

        // R6 set wins over clear
        wr(AEV + 2, 0);
        wr_pulse(AEV + 2, 0, 1'b1, 1'b0);
        rd(AEV + 2, v); chk("R6 set wins", v, 1);

        // R9 suspend / resume, R3 start in hold
        wr(ASU, 1);
        chk("R9 hold on suspend", int'(eng_hold), 1);
        wr(AST, 1);
        chk("R3 no start in hold", int'(eng_start), 0);
        wr(ARS, 1);
        chk("R9 resume drops hold", int'(eng_hold), 0);
        wr(ARS, 1);
        chk("R9 resume in run ignored", int'(eng_hold), 0);
        wr(ASU, 1);
        chk("R9 hold again", int'(eng_hold), 1);

        // R10 stop while busy
        eng_busy = 1'b1;
        wr(ASP, 1);
        chk("R10 eng_stop pulse", int'(eng_stop), 1);
        chk("R10 hold dropped", int'(eng_hold), 0);
        @(negedge clk);
        chk("R10 stop one cycle", int'(eng_stop), 0);
        rd(AEV + 1, v); chk("R10 not stopped while busy", v, 0);
        wr(AST, 1);
        chk("R3 no start while stopping", int'(eng_start), 0);
        eng_busy = 1'b0;
        @(negedge clk);
        rd(AEV + 1, v); chk("R10 stopped flag", v, 1);
        wr(ASU, 1);
        chk("R9 suspend in idle ignored", int'(eng_hold), 0);

        // R7 R8 enables and irq
        for (int k = 0; k < 5; k++) wr(AEV + k, 0);
        chk("R8 no irq with mask zero", int'(irq), 0);
        wr(ASET, 5'h1F);
        rd(ASET, v); chk("R7 mask set", v, 31);
        chk("R8 irq no flags", int'(irq), 0);
        pulse(1'b0, 1'b1);
        chk("R8 irq on tx flag", int'(irq), 1);
        wr(ACLR, 5'h08);
        rd(ACLR, v); chk("R7 mask clear", v, 23);
        chk("R8 irq masked", int'(irq), 0);
        wr(ACLR, 5'h1F);

        // R11 shortcut
        wr(ASC, 1);
        rd(ASC, v); chk("R11 shortcut reads", v, 1);
        wr(AST, 1);
        chk("R11 first start", int'(eng_start), 1);
        wr(AEV, 0);
        pulse(1'b1, 1'b1);
        chk("R11 relaunch", int'(eng_start), 1);
        rd(AEV, v); chk("R11 started again", v, 1);
        rd(AEV + 4, v); chk("R5 end same cycle", v, 1);
        wr(AST, 1);
        chk("R11 still active", int'(eng_start), 0);
        wr(ASC, 0);
        wr(AEV + 4, 0);
        pulse(1'b0, 1'b1);
        rd(AEV + 4, v); chk("R5 no end tx first", v, 0);
        pulse(1'b1, 1'b0);
        chk("R11 no relaunch when off", int'(eng_start), 0);
        rd(AEV + 4, v); chk("R5 end tx then rx", v, 1);
        wr(AST, 1);
        chk("R5 idle after end", int'(eng_start), 1);

        // random phase in idle against a model
        do_reset();
        mev = '0; mien = '0;
        for (int it = 0; it < 300; it++) begin
            int op, m, k;
            op = int'($urandom_range(0, 5));
            m  = int'($urandom_range(0, 31));
            k  = int'($urandom_range(0, 4));
            unique case (op)
                0: begin wr(ASET, m); mien = mien | 5'(m); end
                1: begin wr(ACLR, m); mien = mien & ~5'(m); end
                2: begin wr(AEV + k, 0); mev[k] = 1'b0; end
                3: begin
                    pulse(m[0], m[1]);
                    mev[2] = mev[2] | m[0];
                    mev[3] = mev[3] | m[1];
                end
                4: begin wr(ASP, 1); @(negedge clk); mev[1] = 1'b1; end
                default: wr(AEV + k, 1);
            endcase
            chk("R8 random irq", int'(irq), exp_irq(mev, mien));
            rd(ASET, v); chk("R7 random mask", v, int'(mien));
            rd(AEV + k, v); chk("R6 random flag", v, int'(mev[k]));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule